// File: doc/BRIEF.md
# Low-Power Bus Activity Checker

This block is a passive monitor that sits beside a processor's front-side bus. It tracks the processor's power state from four control lines: stop-clock, sleep, deep-sleep and the processor reset line. It watches a bundle of bus inputs, a snoop strobe and a set of interrupt lines. In the low-power states the processor cannot snoop or latch interrupts, so most bus activity there is illegal. The checker applies a different permitted-activity set to each state. In Sleep only the sleep, deep-sleep and reset controls may move. In Deep Sleep, and during the settling period after it, only the deep-sleep line may move. Snoops are also rejected in the cycle the sleep line changes.

Each rule owns one sticky flag. The checker also records the code of the first rule that fired and the clock count at which it fired. A synchronous clear input empties all of these records. The checker never drives the bus and never corrects anything. It only reports.

Top module: `lpBusChecker`

## Requirements
- R1: While the monitor reset `rstN` is low, the state output reads Run (0), all error flags read 0, the first code reads 0 and the first cycle reads 0.
- R2: The state output uses the encoding Run=0, StopGrant=1, Sleep=2, DeepSleep=3, Wake=4, and it changes one clock edge after its inputs. The transitions are:
  - Run to StopGrant when stop-clock is high.
  - StopGrant back to Run when stop-clock drops; otherwise StopGrant to Sleep when sleep is high.
  - Sleep to StopGrant when sleep is low; otherwise Sleep to DeepSleep when deep-sleep is high.
  - DeepSleep to Wake when deep-sleep is low.
  - Wake to Sleep after SETTLE_CYCLES edges spent in Wake.
  - A high processor reset line forces Run from any state.
- R3: Flag bit 0 is set when the sleep line rises while the state is not StopGrant.
- R4: Flag bit 1 is set when the deep-sleep line rises while the state is not Sleep.
- R5: Flag bit 2 is set when a bus input or an interrupt line changes while the state is Sleep. Changes on the sleep, deep-sleep or processor reset lines in Sleep set no flag.
- R6: Flag bit 3 is set when a bus input, an interrupt line, the sleep line or the processor reset line changes while the state is DeepSleep or Wake. A change on deep-sleep alone sets no flag.
- R7: Flag bit 4 is set when the snoop strobe is high while the state is Sleep, or in any cycle in which the sleep line changes.
- R8: Flag bit 5 is set when the snoop strobe or any interrupt line is high while the state is DeepSleep or Wake.
- R9: Flags are sticky until `clear` is high at a clock edge. That edge zeroes the flags, the first code and the first cycle, and any violation in the same cycle is dropped.
- R10: When no code is held, the first violating edge stores code = (lowest flag bit index that fired in that cycle) + 1. It also stores the number of clock edges counted since `rstN` rose before that edge. Later violations leave both values unchanged.
- R11: Input changes are judged only from the second clock edge after `rstN` rises. The first edge only loads the reference values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rstN | input | 1 | Asynchronous active-low monitor reset |
| clear | input | 1 | Synchronous clear of flags and first-violation record |
| stopClkIn | input | 1 | Stop-clock request line, high = asserted |
| sleepIn | input | 1 | Sleep control line, high = asserted |
| deepSleepIn | input | 1 | Deep-sleep control line, high = asserted |
| cpuResetIn | input | 1 | Processor reset line, high = asserted |
| snoopIn | input | 1 | Snoop strobe |
| irqIn | input | IRQ_W | Interrupt lines |
| busIn | input | BUS_W | Other monitored bus inputs |
| stateOut | output | 3 | Tracked power state |
| errFlags | output | 6 | Sticky per-rule error flags |
| firstCode | output | 3 | Code of the first violation, 0 = none |
| firstCycle | output | CNT_W | Edge count at the first violation |

## Verification
A wrong tracked state shows up at `stateOut` one edge after the input that caused it. It also produces wrong flags on the next violation probe, because every rule is qualified by the state. A missed or extra transition is therefore visible within one cycle, and bus activity aimed at the state exposes the error in the following cycle. A broken first-violation record shows up as a code that does not match the lowest flag set, or as a cycle value that drifts when a later violation arrives.

// File: rtl/lpmPkg.sv
package lpmPkg;

  localparam int NUM_RULES = 6;
  localparam int CODE_W    = 3;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_STOPGRANT = 3'd1,
    ST_SLEEP     = 3'd2,
    ST_DEEP      = 3'd3,
    ST_WAKE      = 3'd4
  } lpmStateE;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic primed;      // reference values valid
    logic sleepEdge;   // sleep line changed this cycle
    logic sleepRise;   // sleep line rose this cycle
    logic deepRise;    // deep-sleep line rose this cycle
    logic ctrlChange;  // sleep or processor reset changed
    logic inStopGrant;
    logic inSleep;
    logic inQuiet;     // DeepSleep or Wake
  } lpmStrobeT;

endpackage

// File: rtl/lpmControl.sv
module lpmControl
  import lpmPkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopClkIn,
  input  logic      sleepIn,
  input  logic      deepSleepIn,
  input  logic      cpuResetIn,
  output lpmStateE  stateOut,
  output lpmStrobeT strb
);

  localparam int WAKE_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(SETTLE_CYCLES - 1);

  lpmStateE          stateQ, stateD;
  logic [WAKE_W-1:0] wakeCntQ, wakeCntD;
  logic              primedQ;
  logic              prevSleep, prevDeep, prevReset;

  always_comb begin
    stateD   = stateQ;
    wakeCntD = wakeCntQ;
    if (cpuResetIn) begin
      stateD   = ST_RUN;
      wakeCntD = '0;
    end else begin
      unique case (stateQ)
        ST_RUN:       if (stopClkIn) stateD = ST_STOPGRANT;
        ST_STOPGRANT: begin
          if (!stopClkIn)   stateD = ST_RUN;
          else if (sleepIn) stateD = ST_SLEEP;
        end
        ST_SLEEP: begin
          if (!sleepIn)         stateD = ST_STOPGRANT;
          else if (deepSleepIn) stateD = ST_DEEP;
        end
        ST_DEEP: begin
          if (!deepSleepIn) begin
            stateD   = ST_WAKE;
            wakeCntD = '0;
          end
        end
        ST_WAKE: begin
          if (wakeCntQ == WAKE_LAST) stateD = ST_SLEEP;
          else                       wakeCntD = wakeCntQ + 1'b1;
        end
        default: stateD = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_RUN;
      wakeCntQ  <= '0;
      primedQ   <= 1'b0;
      prevSleep <= 1'b0;
      prevDeep  <= 1'b0;
      prevReset <= 1'b0;
    end else begin
      stateQ    <= stateD;
      wakeCntQ  <= wakeCntD;
      primedQ   <= 1'b1;
      prevSleep <= sleepIn;
      prevDeep  <= deepSleepIn;
      prevReset <= cpuResetIn;
    end
  end

  always_comb begin
    strb.primed      = primedQ;
    strb.sleepEdge   = primedQ && (sleepIn != prevSleep);
    strb.sleepRise   = primedQ && sleepIn && !prevSleep;
    strb.deepRise    = primedQ && deepSleepIn && !prevDeep;
    strb.ctrlChange  = primedQ && ((sleepIn != prevSleep) || (cpuResetIn != prevReset));
    strb.inStopGrant = (stateQ == ST_STOPGRANT);
    strb.inSleep     = (stateQ == ST_SLEEP);
    strb.inQuiet     = (stateQ == ST_DEEP) || (stateQ == ST_WAKE);
  end

  assign stateOut = stateQ;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    stateQ inside {ST_RUN, ST_STOPGRANT, ST_SLEEP, ST_DEEP, ST_WAKE}); // R2
  AST_DEEP_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stateQ == ST_DEEP) |-> $past(stateQ) == ST_SLEEP); // R2
  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAKE && !cpuResetIn) |=> (stateQ == ST_WAKE || stateQ == ST_SLEEP)); // R2
  AST_RESET_TO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    cpuResetIn |=> stateQ == ST_RUN); // R2

endmodule

// File: rtl/lpmDatapath.sv
module lpmDatapath
  import lpmPkg::*;
#(
  parameter int BUS_W = 8,
  parameter int IRQ_W = 4,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  lpmStrobeT            strb,
  input  logic                 snoopIn,
  input  logic [IRQ_W-1:0]     irqIn,
  input  logic [BUS_W-1:0]     busIn,
  output logic [NUM_RULES-1:0] errFlags,
  output logic [CODE_W-1:0]    firstCode,
  output logic [CNT_W-1:0]     firstCycle
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [BUS_W-1:0]     prevBus;
  logic [IRQ_W-1:0]     prevIrq;
  logic                 busChange;
  logic [NUM_RULES-1:0] viol;
  logic [NUM_RULES-1:0] errQ;
  logic [CODE_W-1:0]    codeQ, newCode;
  logic [CNT_W-1:0]     cycleQ, stampQ;

  assign busChange = strb.primed && ((busIn != prevBus) || (irqIn != prevIrq));

  // One violation term per rule; bit index plus one is the reported code
  always_comb begin
    viol    = '0;
    viol[0] = strb.sleepRise && !strb.inStopGrant;
    viol[1] = strb.deepRise && !strb.inSleep;
    viol[2] = strb.inSleep && busChange;
    viol[3] = strb.inQuiet && (busChange || strb.ctrlChange);
    viol[4] = snoopIn && (strb.inSleep || strb.sleepEdge);
    viol[5] = strb.inQuiet && (snoopIn || (|irqIn));
  end

  always_comb begin
    newCode = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (viol[i]) newCode = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBus <= '0;
      prevIrq <= '0;
      cycleQ  <= '0;
    end else begin
      prevBus <= busIn;
      prevIrq <= irqIn;
      if (cycleQ != CNT_MAX) cycleQ <= cycleQ + 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_RULES; g++) begin : gFlag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       errQ[g] <= 1'b0;
        else if (clear)  errQ[g] <= 1'b0;
        else if (viol[g]) errQ[g] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ  <= '0;
      stampQ <= '0;
    end else if (clear) begin
      codeQ  <= '0;
      stampQ <= '0;
    end else if (codeQ == '0 && (|viol)) begin
      codeQ  <= newCode;
      stampQ <= cycleQ;
    end
  end

  assign errFlags   = errQ;
  assign firstCode  = codeQ;
  assign firstCycle = stampQ;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> ((errQ & $past(errQ)) == $past(errQ))); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (errQ == '0 && codeQ == '0 && stampQ == '0)); // R9
  AST_CODE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ != '0) |-> errQ[codeQ - 1'b1]); // R10
  AST_CODE_WITH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ == '0) == (errQ == '0)); // R10
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ != '0 && !clear) |=> ($stable(codeQ) && $stable(stampQ))); // R10
  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inQuiet && (|irqIn) && !clear) |=> errQ[5]); // R8

endmodule

// File: rtl/lpBusChecker.sv
module lpBusChecker
  import lpmPkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int IRQ_W         = 4,
  parameter int SETTLE_CYCLES = 8,
  parameter int CNT_W         = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic                 stopClkIn,
  input  logic                 sleepIn,
  input  logic                 deepSleepIn,
  input  logic                 cpuResetIn,
  input  logic                 snoopIn,
  input  logic [IRQ_W-1:0]     irqIn,
  input  logic [BUS_W-1:0]     busIn,
  output logic [2:0]           stateOut,
  output logic [NUM_RULES-1:0] errFlags,
  output logic [CODE_W-1:0]    firstCode,
  output logic [CNT_W-1:0]     firstCycle
);

  lpmStrobeT strb;
  lpmStateE  stateE;

  lpmControl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .stopClkIn  (stopClkIn),
    .sleepIn    (sleepIn),
    .deepSleepIn(deepSleepIn),
    .cpuResetIn (cpuResetIn),
    .stateOut   (stateE),
    .strb       (strb)
  );

  lpmDatapath #(.BUS_W(BUS_W), .IRQ_W(IRQ_W), .CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .strb      (strb),
    .snoopIn   (snoopIn),
    .irqIn     (irqIn),
    .busIn     (busIn),
    .errFlags  (errFlags),
    .firstCode (firstCode),
    .firstCycle(firstCycle)
  );

  assign stateOut = stateE;

endmodule

// File: tb/lpBusChecker_tb.sv
module lpBusChecker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 8;
  localparam int IRQ_W = 4;
  localparam int SETTLE = 3;
  localparam int CNT_W = 16;
  localparam int NROWS = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic stopClkIn = 1'b0, sleepIn = 1'b0, deepSleepIn = 1'b0, cpuResetIn = 1'b0, snoopIn = 1'b0;
  logic [IRQ_W-1:0] irqIn = '0;
  logic [BUS_W-1:0] busIn = '0;
  logic [2:0] stateOut;
  logic [5:0] errFlags;
  logic [2:0] firstCode;
  logic [CNT_W-1:0] firstCycle;

  int testsRun = 0;
  int testsFailed = 0;
  logic [CNT_W-1:0] tbCycle;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) tbCycle <= '0;
    else       tbCycle <= tbCycle + 1'b1;
  end

  lpBusChecker #(.BUS_W(BUS_W), .IRQ_W(IRQ_W), .SETTLE_CYCLES(SETTLE), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .clear(clear),
    .stopClkIn(stopClkIn), .sleepIn(sleepIn), .deepSleepIn(deepSleepIn),
    .cpuResetIn(cpuResetIn), .snoopIn(snoopIn), .irqIn(irqIn), .busIn(busIn),
    .stateOut(stateOut), .errFlags(errFlags), .firstCode(firstCode), .firstCycle(firstCycle)
  );

  typedef struct packed {
    logic stp; logic slp; logic dps; logic rst; logic snp;
    logic [3:0] irq; logic [7:0] bus; logic clr;
    logic [2:0] st; logic [5:0] err;
  } rowT;

  // stp slp dps rst snp irq bus clr | expected state, expected flags
  localparam rowT TBL [NROWS] = '{
    '{0,0,0,0,0,4'h0,8'h00,0, 3'd0,6'h00}, // 0  idle Run
    '{0,0,0,0,0,4'h0,8'h5A,0, 3'd0,6'h00}, // 1  bus moves in Run
    '{1,0,0,0,0,4'h0,8'h5A,0, 3'd1,6'h00}, // 2  StopGrant
    '{1,1,0,0,0,4'h0,8'h5A,0, 3'd2,6'h00}, // 3  Sleep
    '{1,1,1,0,0,4'h0,8'h5A,0, 3'd3,6'h00}, // 4  DeepSleep
    '{1,1,1,0,0,4'h0,8'h5A,0, 3'd3,6'h00}, // 5
    '{1,1,0,0,0,4'h0,8'h5A,0, 3'd4,6'h00}, // 6  Wake
    '{1,1,0,0,0,4'h0,8'h5A,0, 3'd4,6'h00}, // 7
    '{1,1,0,0,0,4'h0,8'h5A,0, 3'd4,6'h00}, // 8
    '{1,1,0,0,0,4'h0,8'h5A,0, 3'd2,6'h00}, // 9  back to Sleep
    '{1,0,0,0,0,4'h0,8'h5A,0, 3'd1,6'h00}, // 10 StopGrant
    '{0,0,0,0,0,4'h0,8'h5A,0, 3'd0,6'h00}, // 11 Run
    '{0,1,0,0,0,4'h0,8'h5A,0, 3'd0,6'h01}, // 12 R3 sleep in Run
    '{0,0,0,0,0,4'h0,8'h5A,1, 3'd0,6'h00}, // 13 clear
    '{0,0,1,0,0,4'h0,8'h5A,0, 3'd0,6'h02}, // 14 R4 deep in Run
    '{0,0,0,0,0,4'h0,8'h5A,1, 3'd0,6'h00}, // 15 clear
    '{1,0,0,0,0,4'h0,8'h5A,0, 3'd1,6'h00}, // 16
    '{1,1,0,0,1,4'h0,8'h5A,0, 3'd2,6'h10}, // 17 R7 snoop at entry
    '{1,1,0,0,0,4'h0,8'h5A,1, 3'd2,6'h00}, // 18 clear
    '{1,1,0,0,0,4'h0,8'hA5,0, 3'd2,6'h04}, // 19 R5 bus in Sleep
    '{1,1,0,0,0,4'h0,8'hA5,1, 3'd2,6'h00}, // 20 clear
    '{1,1,0,1,0,4'h0,8'hA5,0, 3'd0,6'h00}, // 21 R5 reset legal in Sleep
    '{0,0,0,0,0,4'h0,8'hA5,0, 3'd0,6'h00}, // 22
    '{1,0,0,0,0,4'h0,8'hA5,0, 3'd1,6'h00}, // 23
    '{1,1,0,0,0,4'h0,8'hA5,0, 3'd2,6'h00}, // 24
    '{1,1,1,0,0,4'h0,8'hA5,0, 3'd3,6'h00}, // 25
    '{1,1,1,0,0,4'h1,8'hA5,0, 3'd3,6'h28}, // 26 R6 R8 irq in Deep
    '{1,1,1,0,0,4'h0,8'hA5,1, 3'd3,6'h00}, // 27 clear wins
    '{1,1,1,0,1,4'h0,8'hA5,0, 3'd3,6'h20}, // 28 R8 snoop in Deep
    '{1,1,1,0,0,4'h0,8'hA5,1, 3'd3,6'h00}, // 29
    '{1,1,0,0,0,4'h0,8'hA5,0, 3'd4,6'h00}, // 30 Wake
    '{1,0,0,0,0,4'h0,8'hA5,0, 3'd4,6'h08}, // 31 R6 sleep drop in Wake
    '{1,0,0,0,0,4'h0,8'hA5,1, 3'd4,6'h00}, // 32
    '{1,0,0,0,0,4'h0,8'hA5,0, 3'd2,6'h00}, // 33
    '{1,0,0,0,0,4'h0,8'hA5,0, 3'd1,6'h00}, // 34
    '{0,0,0,0,0,4'h0,8'hA5,0, 3'd0,6'h00}  // 35
  };

  task automatic check(input string req, input string what, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic stp, slp, dps, rst, snp, input logic [3:0] irq,
                       input logic [7:0] bus, input logic clr);
    stopClkIn = stp; sleepIn = slp; deepSleepIn = dps; cpuResetIn = rst;
    snoopIn = snp; irqIn = irq; busIn = bus; clear = clr;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [CNT_W-1:0] expStamp;
    // R1 reset values
    repeat (3) @(negedge clk);
    check("R1", "state", stateOut, 0);
    check("R1", "flags", errFlags, 0);
    check("R1", "code", firstCode, 0);
    check("R1", "cycle", firstCycle, 0);
    rstN = 1'b1;

    // R2-R9 table walk
    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].stp, TBL[i].slp, TBL[i].dps, TBL[i].rst, TBL[i].snp,
            TBL[i].irq, TBL[i].bus, TBL[i].clr);
      @(negedge clk);
      check("R2", $sformatf("row %0d state", i), stateOut, TBL[i].st);
      check("R3-R9", $sformatf("row %0d flags", i), errFlags, TBL[i].err);
    end

    // R11 sleep held high through reset release: no false edge
    drive(0, 1, 0, 0, 0, 4'h0, 8'h33, 0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "flags after release", errFlags, 0);
    check("R11", "state", stateOut, 0);

    // R10 first record, lowest code among simultaneous rules
    drive(0, 0, 0, 0, 0, 4'h0, 8'h33, 0);
    repeat (4) @(negedge clk);
    drive(0, 1, 1, 0, 0, 4'h0, 8'h33, 0);
    expStamp = tbCycle;
    @(negedge clk);
    check("R10", "flags both", errFlags, 6'h03);
    check("R10", "first code", firstCode, 1);
    check("R10", "first cycle", firstCycle, expStamp);
    drive(1, 0, 0, 0, 0, 4'h0, 8'h33, 0);
    @(negedge clk);
    drive(1, 1, 0, 0, 0, 4'h0, 8'h33, 0);
    @(negedge clk);
    check("R2", "sleep reached", stateOut, 2);
    drive(1, 1, 0, 0, 0, 4'h0, 8'hC3, 0);
    @(negedge clk);
    check("R9", "flags accumulate", errFlags, 6'h07);
    check("R10", "code kept", firstCode, 1);
    check("R10", "cycle kept", firstCycle, expStamp);
    drive(1, 1, 0, 0, 0, 4'h0, 8'hC3, 1);
    @(negedge clk);
    check("R9", "cleared flags", errFlags, 0);
    check("R9", "cleared code", firstCode, 0);
    check("R9", "cleared cycle", firstCycle, 0);

    finishRun();
  end

endmodule